// File: doc/BRIEF.md
# DRAM Controller Configuration Register Bank

This block is the software-visible configuration space of a DRAM controller. It holds an array of 32-bit words behind a plain word-addressed register bus (word address, write enable, write data, read data). Writes go through a key-operated protection word. The protection state can be open, soft-locked or hard-locked. Soft lock still lets software rewrite the protection word. Hard lock is sticky until reset. A small set of run-time registers is exempt from protection and always accepts writes.

Several registers rewrite incoming data before it is stored. The configuration word keeps its read-only fields, and forces a version field, an aperture field and a memory-size code. The PHY status word never reports busy and always reports the PLL as locked. The ECC self-test control word always reports finished and never failed. At reset the bank returns to soft lock, and the configuration word and the PHY calibration words take non-zero defaults. The memory-size code is taken from a pin while reset is asserted.

Top module: `dram_cfg_regbank`

## Requirements
- R1: During reset the size code is taken from `size_code_i`. After reset every word reads zero except these: the configuration word (word 0x01) reads 0x3000000C OR size code, word 0x100 reads 0x00000002, words 0x11A and 0x11F read 0x000000FF, and word 0x114 reads 0x0FFFFFFF. The protection word (word 0x00) reads 0x00, which means soft-locked.
- R2: A permitted write to word 0x00 sets the protection state. Data 0xFC600309 makes it read 0x01 (open), data 0xDEADDEAD makes it read 0x10 (hard), and any other data makes it read 0x00 (soft).
- R3: While soft-locked, a write to any in-range word other than word 0x00 and the exempt words is discarded. A write to word 0x00 is still accepted.
- R4: While hard-locked, every write to a non-exempt word is discarded, word 0x00 included. Only reset leaves this state.
- R5: Words 0x14, 0x1B, 0x1D, 0x1E, 0x1F, 0x22, 0x23 and 0x2D store written data unchanged in every protection state.
- R6: An accepted write to the configuration word stores (data AND 0x0FF03FB0) OR 0x3000000C OR size code. This forces bits 31:28 to 3, bits 3:2 to 3 and bits 1:0 to the size code, and drops bits 19:14 and bit 6.
- R7: An accepted write to word 0x18 stores the data with bit 0 cleared and bit 4 set.
- R8: An accepted write to word 0x1C stores the data with bit 12 set and bit 13 cleared.
- R9: The window spans 1024 words and NUM_WORDS words are implemented. A read of a word at or above NUM_WORDS returns zero. A write to such a word has no effect and raises no reject.
- R10: Read data appears one cycle after the address is presented. A read of a word in the same cycle as a write to that word returns the value held before the write.
- R11: `wr_reject_o` is high for exactly the one cycle after each write discarded by protection, and is low at all other times.
- R12: After reset, changes on `size_code_i` have no effect on the forced size field until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also samples the size code |
| size_code_i | input | 2 | Memory size code (0: 256 MB, 1: 512 MB, 2: 1 GB, 3: 2 GB) |
| addr_i | input | WORD_W (10) | Word address within the 4 KB window |
| wr_en_i | input | 1 | Write strobe for the addressed word |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for the address presented one cycle earlier |
| wr_reject_o | output | 1 | One-cycle pulse after a write blocked by protection |

## Verification
The bench builds the block with its defaults: a 10-bit word address over a 1024-word window, and NUM_WORDS = 512 implemented words. With these values the PHY calibration words near word 0x11F and the unimplemented upper half of the window (word 0x200 and above) can both be reached, so the zero-read and ignored-write behaviour is exercised on real addresses. The size code is varied across resets, and it is also changed after reset, to show that only the value taken during reset reaches the configuration word.

// File: rtl/dram_cfg_pkg.sv
`timescale 1ns/1ps
package dram_cfg_pkg;

  typedef enum logic [1:0] {
    LK_SOFT = 2'd0,
    LK_OPEN = 2'd1,
    LK_HARD = 2'd2
  } lock_e;

  localparam logic [31:0] KEY_OPEN  = 32'hFC60_0309;
  localparam logic [31:0] KEY_HARD  = 32'hDEAD_DEAD;

  // word indices with special behaviour
  localparam int W_PROT  = 0;
  localparam int W_CONF  = 1;
  localparam int W_STAT  = 24;   // 0x18
  localparam int W_ECC   = 28;   // 0x1C
  localparam int W_PHY   = 256;  // 0x100
  localparam int W_EYE_C = 276;  // 0x114
  localparam int W_EYE_A = 282;  // 0x11A
  localparam int W_EYE_B = 287;  // 0x11F

  localparam logic [31:0] CONF_KEEP = 32'h0FF0_3FB0;
  localparam logic [31:0] CONF_FIX  = 32'h3000_000C;

  localparam int N_EXEMPT = 8;
  localparam int EXEMPT_W [N_EXEMPT] = '{20, 27, 29, 30, 31, 34, 35, 45};

  function automatic logic is_exempt(input int unsigned w);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < N_EXEMPT; i++) begin
      if (w == EXEMPT_W[i]) hit = 1'b1;
    end
    return hit;
  endfunction

  function automatic logic [31:0] lock_word(input lock_e s);
    case (s)
      LK_OPEN: return 32'h0000_0001;
      LK_HARD: return 32'h0000_0010;
      default: return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/dram_cfg_lock.sv
`timescale 1ns/1ps
module dram_cfg_lock
  import dram_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        prot_we,
  input  logic [31:0] prot_data,
  output lock_e       state_o
);

  lock_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LK_SOFT;
    end else if (prot_we) begin
      if (prot_data == KEY_OPEN)      state_q <= LK_OPEN;
      else if (prot_data == KEY_HARD) state_q <= LK_HARD;
      else                            state_q <= LK_SOFT;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/dram_cfg_wfilter.sv
`timescale 1ns/1ps
module dram_cfg_wfilter
  import dram_cfg_pkg::*;
#(
  parameter int WORD_W    = 10,
  parameter int NUM_WORDS = 512
) (
  input  logic              wr_en,
  input  logic [WORD_W-1:0] word,
  input  logic [31:0]       data,
  input  lock_e             lock,
  input  logic [1:0]        size_code,
  output logic              prot_we,
  output logic              store_we,
  output logic [31:0]       store_data,
  output logic              reject
);

  logic in_rng, exempt, is_prot, allowed;

  always_comb begin
    in_rng  = 32'(word) < NUM_WORDS;
    exempt  = is_exempt(32'(word));
    is_prot = (32'(word) == W_PROT);
    allowed = exempt || (lock == LK_OPEN) || ((lock == LK_SOFT) && is_prot);

    prot_we  = wr_en && in_rng && is_prot && allowed;
    store_we = wr_en && in_rng && !is_prot && allowed;
    reject   = wr_en && in_rng && !allowed;

    store_data = data;
    if (32'(word) == W_CONF) begin
      store_data = (data & CONF_KEEP) | CONF_FIX | {30'd0, size_code};
    end else if (32'(word) == W_STAT) begin
      store_data = (data & ~32'h0000_0001) | 32'h0000_0010;
    end else if (32'(word) == W_ECC) begin
      store_data = (data | 32'h0000_1000) & ~32'h0000_2000;
    end
  end

endmodule

// File: rtl/dram_cfg_store.sv
`timescale 1ns/1ps
module dram_cfg_store
  import dram_cfg_pkg::*;
#(
  parameter int NUM_WORDS = 512,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       size_code,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [31:0]      wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [31:0]      rdata
);

  logic [31:0]          mem [NUM_WORDS];
  logic [NUM_WORDS-1:0] vld;
  logic [31:0]          mem_q, dflt_q;
  logic                 vld_q;

  function automatic logic [31:0] reset_value(input int unsigned w, input logic [1:0] sz);
    case (w)
      W_CONF:  return CONF_FIX | {30'd0, sz};
      W_PHY:   return 32'h0000_0002;
      W_EYE_A: return 32'h0000_00FF;
      W_EYE_B: return 32'h0000_00FF;
      W_EYE_C: return 32'h0FFF_FFFF;
      default: return 32'h0000_0000;
    endcase
  endfunction

  // data array: no reset, read-first, so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    mem_q <= mem[raddr];
  end

  // per-word "written since reset" flags
  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= '0;
      vld_q <= 1'b0;
    end else begin
      if (we) vld[waddr] <= 1'b1;
      vld_q <= vld[raddr];
    end
  end

  always_ff @(posedge clk) begin
    dflt_q <= reset_value(32'(raddr), size_code);
  end

  assign rdata = vld_q ? mem_q : dflt_q;

endmodule

// File: rtl/dram_cfg_regbank.sv
`timescale 1ns/1ps
module dram_cfg_regbank
  import dram_cfg_pkg::*;
#(
  parameter int WORD_W    = 10,
  parameter int NUM_WORDS = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        size_code_i,
  input  logic [WORD_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       rd_data_o,
  output logic              wr_reject_o
);

  localparam int IDX_W = $clog2(NUM_WORDS);

  typedef enum logic [1:0] {RS_ZERO, RS_PROT, RS_STORE} rsel_e;

  logic [1:0]  size_q;
  lock_e       lock_s;
  logic        prot_we, store_we, reject;
  logic [31:0] store_data, store_rd, prot_rd_q;
  rsel_e       rsel_q;
  logic        reject_q;

  always_ff @(posedge clk) begin
    if (rst) size_q <= size_code_i;
  end

  dram_cfg_lock u_lock (
    .clk       (clk),
    .rst       (rst),
    .prot_we   (prot_we),
    .prot_data (wr_data_i),
    .state_o   (lock_s)
  );

  dram_cfg_wfilter #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_filter (
    .wr_en      (wr_en_i),
    .word       (addr_i),
    .data       (wr_data_i),
    .lock       (lock_s),
    .size_code  (size_q),
    .prot_we    (prot_we),
    .store_we   (store_we),
    .store_data (store_data),
    .reject     (reject)
  );

  dram_cfg_store #(.NUM_WORDS(NUM_WORDS)) u_store (
    .clk       (clk),
    .rst       (rst),
    .size_code (size_q),
    .we        (store_we),
    .waddr     (addr_i[IDX_W-1:0]),
    .wdata     (store_data),
    .raddr     (addr_i[IDX_W-1:0]),
    .rdata     (store_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q    <= RS_ZERO;
      prot_rd_q <= '0;
      reject_q  <= 1'b0;
    end else begin
      reject_q  <= reject;
      prot_rd_q <= lock_word(lock_s);
      if (32'(addr_i) >= NUM_WORDS)      rsel_q <= RS_ZERO;
      else if (32'(addr_i) == W_PROT)    rsel_q <= RS_PROT;
      else                               rsel_q <= RS_STORE;
    end
  end

  always_comb begin
    case (rsel_q)
      RS_PROT:  rd_data_o = prot_rd_q;
      RS_STORE: rd_data_o = store_rd;
      default:  rd_data_o = '0;
    endcase
  end

  assign wr_reject_o = reject_q;

endmodule

// File: rtl/dram_cfg_regbank_chk.sv
`timescale 1ns/1ps
module dram_cfg_regbank_chk
  import dram_cfg_pkg::*;
#(
  parameter int WORD_W    = 10,
  parameter int NUM_WORDS = 512
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [31:0]       wr_data_i,
  input logic [31:0]       rd_data_o,
  input logic              wr_reject_o,
  input lock_e             lock_q
);

  logic in_rng, exm, at_prot;
  assign in_rng  = 32'(addr_i) < NUM_WORDS;
  assign exm     = is_exempt(32'(addr_i));
  assign at_prot = 32'(addr_i) == W_PROT;

  // R4: hard lock is sticky until reset
  p_hard_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    lock_q == LK_HARD |=> lock_q == LK_HARD);

  // R2: the opening key takes effect when not hard-locked
  p_key_open_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && at_prot && wr_data_i == KEY_OPEN && lock_q != LK_HARD) |=> lock_q == LK_OPEN);

  // R2: the hard key takes effect when not hard-locked
  p_key_hard_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && at_prot && wr_data_i == KEY_HARD && lock_q != LK_HARD) |=> lock_q == LK_HARD);

  // R3: soft lock blocks protected non-key writes
  p_soft_block_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && lock_q == LK_SOFT && in_rng && !at_prot && !exm) |=> wr_reject_o);

  // R5: exempt words never raise a reject
  p_exempt_pass_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && exm) |=> !wr_reject_o);

  // R9: out-of-range reads return zero
  p_oor_read_r9: assert property (@(posedge clk) disable iff (rst)
    !in_rng |=> rd_data_o == 32'd0);

  // R9: out-of-range writes raise no reject
  p_oor_write_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !in_rng) |=> !wr_reject_o);

  // R11: a reject only follows a write
  p_reject_cause_r11: assert property (@(posedge clk) disable iff (rst)
    wr_reject_o |-> $past(wr_en_i));

endmodule

bind dram_cfg_regbank dram_cfg_regbank_chk #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .addr_i      (addr_i),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .rd_data_o   (rd_data_o),
  .wr_reject_o (wr_reject_o),
  .lock_q      (lock_s)
);

// File: tb/dram_cfg_regbank_tb_top.sv
`timescale 1ns/1ps
module dram_cfg_regbank_tb_top;

  localparam int WORD_W = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        size_code = 2'd0;
  logic [WORD_W-1:0] addr = '0;
  logic              we = 1'b0;
  logic [31:0]       wd = '0;
  logic [31:0]       rd;
  logic              rej;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  dram_cfg_regbank #(.WORD_W(WORD_W), .NUM_WORDS(512)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .size_code_i (size_code),
    .addr_i      (addr),
    .wr_en_i     (we),
    .wr_data_i   (wd),
    .rd_data_o   (rd),
    .wr_reject_o (rej)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] code);
    @(negedge clk);
    rst = 1'b1; size_code = code; we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input int w, input logic [31:0] d, output logic r);
    @(negedge clk);
    addr = WORD_W'(w); we = 1'b1; wd = d;
    @(posedge clk); #1;
    r = rej;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rdw(input int w, output logic [31:0] v);
    @(negedge clk);
    addr = WORD_W'(w); we = 1'b0;
    @(posedge clk); #1;
    v = rd;
  endtask

  task automatic t_reset_values();
    logic [31:0] v;
    do_reset(2'd0);
    rdw(0, v);     chk("R1 prot after reset", v, 32'h0);
    rdw(1, v);     chk("R1 conf code0", v, 32'h3000000C);
    rdw(256, v);   chk("R1 phy status", v, 32'h2);
    rdw(276, v);   chk("R1 eye 0x114", v, 32'h0FFFFFFF);
    rdw(282, v);   chk("R1 eye 0x11A", v, 32'hFF);
    rdw(287, v);   chk("R1 eye 0x11F", v, 32'hFF);
    rdw(32, v);    chk("R1 plain word", v, 32'h0);
    do_reset(2'd3);
    rdw(1, v);     chk("R1 conf code3", v, 32'h3000000F);
  endtask

  task automatic t_keys();
    logic [31:0] v; logic r;
    do_reset(2'd0);
    wr(0, 32'hFC600309, r); rdw(0, v); chk("R2 open key", v, 32'h1);
    wr(0, 32'h12345678, r); rdw(0, v); chk("R2 other value", v, 32'h0);
    wr(0, 32'hDEADDEAD, r); rdw(0, v); chk("R2 hard key", v, 32'h10);
  endtask

  task automatic t_soft_lock();
    logic [31:0] v; logic r;
    do_reset(2'd0);
    wr(32, 32'hA5A5A5A5, r); chk("R3 soft reject", {31'd0, r}, 32'd1);
    rdw(32, v);              chk("R3 soft discard", v, 32'h0);
    wr(1, 32'h0, r);         rdw(1, v); chk("R3 conf kept", v, 32'h3000000C);
    wr(0, 32'hFC600309, r);  chk("R3 prot writable", {31'd0, r}, 32'd0);
    rdw(0, v);               chk("R3 unlocked", v, 32'h1);
  endtask

  task automatic t_hard_lock();
    logic [31:0] v; logic r;
    do_reset(2'd0);
    wr(0, 32'hDEADDEAD, r);
    wr(0, 32'hFC600309, r);  chk("R4 key rejected", {31'd0, r}, 32'd1);
    rdw(0, v);               chk("R4 stays hard", v, 32'h10);
    wr(40, 32'h11112222, r); rdw(40, v); chk("R4 data discarded", v, 32'h0);
    do_reset(2'd0);
    rdw(0, v);               chk("R4 reset leaves hard", v, 32'h0);
  endtask

  task automatic t_exempt();
    logic [31:0] v; logic r;
    int ex [8] = '{20, 27, 29, 30, 31, 34, 35, 45};
    do_reset(2'd0);
    wr(0, 32'hDEADDEAD, r);
    for (int i = 0; i < 8; i++) begin
      wr(ex[i], 32'hC0DE0000 + 32'(i), r);
      chk("R5 exempt no reject", {31'd0, r}, 32'd0);
      rdw(ex[i], v);
      chk("R5 exempt stored", v, 32'hC0DE0000 + 32'(i));
    end
  endtask

  task automatic t_transforms();
    logic [31:0] v; logic r;
    do_reset(2'd2);
    wr(0, 32'hFC600309, r);
    wr(1, 32'hFFFFFFFF, r);  rdw(1, v);  chk("R6 conf ones", v, 32'h3FF03FBE);
    wr(1, 32'h0, r);         rdw(1, v);  chk("R6 conf zero", v, 32'h3000000E);
    wr(24, 32'hFFFFFFFF, r); rdw(24, v); chk("R7 status ones", v, 32'hFFFFFFFE);
    wr(24, 32'h0, r);        rdw(24, v); chk("R7 status zero", v, 32'h10);
    wr(28, 32'hFFFFFFFF, r); rdw(28, v); chk("R8 ecc ones", v, 32'hFFFFDFFF);
    wr(28, 32'h0, r);        rdw(28, v); chk("R8 ecc zero", v, 32'h1000);
  endtask

  task automatic t_out_of_range();
    logic [31:0] v; logic r;
    do_reset(2'd0);
    wr(0, 32'hFC600309, r);
    wr(512, 32'hFFFFFFFF, r); chk("R9 oor no reject", {31'd0, r}, 32'd0);
    rdw(512, v);              chk("R9 oor read", v, 32'h0);
    rdw(1023, v);             chk("R9 top read", v, 32'h0);
    rdw(0, v);                chk("R9 lock untouched", v, 32'h1);
    do_reset(2'd0);
    wr(600, 32'h1, r);        chk("R9 oor soft no reject", {31'd0, r}, 32'd0);
  endtask

  task automatic t_read_timing();
    logic [31:0] v; logic r;
    do_reset(2'd0);
    wr(0, 32'hFC600309, r);
    wr(48, 32'hAAAA0001, r);
    @(negedge clk);
    addr = WORD_W'(48); we = 1'b1; wd = 32'hBBBB0002;
    @(posedge clk); #1;
    chk("R10 read old on write", rd, 32'hAAAA0001);
    @(negedge clk); we = 1'b0;
    @(posedge clk); #1;
    chk("R10 new value next", rd, 32'hBBBB0002);
  endtask

  task automatic t_reject_pulse();
    logic r;
    do_reset(2'd0);
    chk("R11 idle low", {31'd0, rej}, 32'd0);
    wr(50, 32'h5, r);
    chk("R11 pulse high", {31'd0, r}, 32'd1);
    @(posedge clk); #1;
    chk("R11 pulse one cycle", {31'd0, rej}, 32'd0);
    wr(0, 32'hFC600309, r);
    chk("R11 accepted low", {31'd0, r}, 32'd0);
  endtask

  task automatic t_size_sample();
    logic [31:0] v; logic r;
    do_reset(2'd2);
    size_code = 2'd1;
    rdw(1, v);               chk("R12 default holds", v, 32'h3000000E);
    wr(0, 32'hFC600309, r);
    wr(1, 32'h0, r);         rdw(1, v); chk("R12 forced holds", v, 32'h3000000E);
    do_reset(2'd1);
    rdw(1, v);               chk("R12 new after reset", v, 32'h3000000D);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_values();
    t_keys();
    t_soft_lock();
    t_hard_lock();
    t_exempt();
    t_transforms();
    t_out_of_range();
    t_read_timing();
    t_reject_pulse();
    t_size_sample();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule